// File: doc/BRIEF.md
# Windowed Readout Address Sequencer

This block walks a pixel array row by row and produces the row and column address of every pixel to be read, together with a line-valid strobe and a frame-valid envelope. The scan is confined to a rectangular window given by inclusive low and high bounds on each axis, inside a 1600 x 1200 array. A one-cycle start pulse launches a frame. The window bounds, the mode bits and the blanking length are captured at that pulse, and the frame then runs to completion on those values.

Two mode bits reverse the scan. One reverses the order of columns within each row, so every row is read from the high bound down to the low bound. The other reverses the order of rows in the same way. Two further bits select 2x subsampling. On an axis with subsampling on, the sequencer reads two neighbouring addresses, passes over the next two, and repeats. This keeps each two-pixel colour pair of the mosaic whole. A programmable number of idle cycles, with line-valid low and frame-valid high, separates one row from the next.

Top module: `readout_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no start pulse, line_valid and frame_valid are both 0.
- R2: A start pulse sampled while no frame is running makes frame_valid and line_valid 1 on the next clock edge. At that edge the addresses show the first pixel: column x_lo (x_hi when mirror=1) and row y_lo (y_hi when flip=1).
- R3: With all mode bits 0, each row gives columns x_lo, x_lo+1, ..., x_hi, one per cycle. Rows run from y_lo up to y_hi.
- R4: With mirror=1, each row gives columns x_hi, x_hi-1, ..., x_lo.
- R5: With flip=1, rows are visited from y_hi down to y_lo.
- R6: With col_skip=1, the columns read are those at distance d from the scan origin (x_lo, or x_hi when mirror=1) with d mod 4 equal to 0 or 1 and d no larger than x_hi-x_lo.
- R7: With row_skip=1, the rows read are those at distance d from the row origin (y_lo, or y_hi when flip=1) with d mod 4 equal to 0 or 1 and d no larger than y_hi-y_lo.
- R8: Between two rows of a frame there are exactly gap_len cycles with line_valid 0 and frame_valid 1. When gap_len is 0, the rows follow back to back.
- R9: On the cycle after the last pixel of the last row, frame_valid and line_valid are 0.
- R10: Window, mode and gap inputs, and start pulses that arrive while a frame runs, have no effect on that frame.
- R11: line_valid is never 1 while frame_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Start-of-frame pulse |
| x_lo | input | 11 | Lowest column of the window |
| x_hi | input | 11 | Highest column of the window |
| y_lo | input | 11 | Lowest row of the window |
| y_hi | input | 11 | Highest row of the window |
| mirror | input | 1 | Scan columns from high to low |
| flip | input | 1 | Scan rows from high to low |
| col_skip | input | 1 | 2x column subsampling by pairs |
| row_skip | input | 1 | 2x row subsampling by pairs |
| gap_len | input | 8 | Idle cycles between rows |
| row_addr | output | 11 | Current row address |
| col_addr | output | 11 | Current column address |
| line_valid | output | 1 | A pixel address is presented this cycle |
| frame_valid | output | 1 | A frame is in progress |

## Verification
The assertions assume a well-formed window: x_lo <= x_hi and y_lo <= y_hi, with both bounds inside the array. The stepping and in-window checks depend on that order to hold. The bench only ever sets windows that meet these conditions. It sweeps every combination of the four mode bits over a small interior window, a one-pixel window and a window at the far corner of the array, each with zero and non-zero blanking. During the frames that deliberately disturb the inputs, the scrambled window still satisfies the order condition, so the frame in progress is unaffected and nothing outside the stated input range ever reaches the block.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
    localparam int ARRAY_COLS = 1600;
    localparam int ARRAY_ROWS = 1200;
    localparam int COL_W      = $clog2(ARRAY_COLS);
    localparam int ROW_W      = $clog2(ARRAY_ROWS);
    localparam int GAP_W      = 8;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LINE = 2'd1,
        PH_GAP  = 2'd2
    } phase_e;

    typedef struct packed {
        logic [COL_W-1:0] xs;
        logic [COL_W-1:0] xe;
        logic [ROW_W-1:0] ys;
        logic [ROW_W-1:0] ye;
        logic             mir;
        logic             flp;
        logic             cskip;
        logic             rskip;
        logic [GAP_W-1:0] gap;
    } scan_cfg_t;

    typedef struct packed {
        phase_e           ph;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [GAP_W-1:0] cnt;
        scan_cfg_t        cfg;
    } seq_t;
endpackage

// File: rtl/axis_step.sv
module axis_step #(
    parameter int W = 11
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    input  logic         rev,
    input  logic         skip,
    output logic [W-1:0] nxt,
    output logic         last
);
    localparam int XW = W + 2;

    logic       odd_pos;
    logic [1:0] step;
    logic [XW-1:0] sum_up;
    logic [XW-1:0] lo_plus;

    always_comb begin
        // parity of distance from scan origin equals xor of the low bits
        odd_pos = rev ? (hi[0] ^ cur[0]) : (cur[0] ^ lo[0]);
        step    = (skip && odd_pos) ? 2'd3 : 2'd1;
        sum_up  = {2'b00, cur} + {{W{1'b0}}, step};
        lo_plus = {2'b00, lo} + {{W{1'b0}}, step};
        if (rev) begin
            nxt  = cur - {{(W-2){1'b0}}, step};
            last = ({2'b00, cur} < lo_plus);
        end else begin
            nxt  = sum_up[W-1:0];
            last = (sum_up > {2'b00, hi});
        end
    end
endmodule

// File: rtl/readout_seq.sv
module readout_seq
    import rdo_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic [COL_W-1:0] x_lo,
    input  logic [COL_W-1:0] x_hi,
    input  logic [ROW_W-1:0] y_lo,
    input  logic [ROW_W-1:0] y_hi,
    input  logic             mirror,
    input  logic             flip,
    input  logic             col_skip,
    input  logic             row_skip,
    input  logic [GAP_W-1:0] gap_len,
    output logic [ROW_W-1:0] row_addr,
    output logic [COL_W-1:0] col_addr,
    output logic             line_valid,
    output logic             frame_valid
);
    seq_t q, d;

    logic [COL_W-1:0] col_nxt;
    logic             col_last;
    logic [ROW_W-1:0] row_nxt;
    logic             row_last;
    logic [COL_W-1:0] col_first;

    axis_step #(.W(COL_W)) u_col (
        .cur (q.col),
        .lo  (q.cfg.xs),
        .hi  (q.cfg.xe),
        .rev (q.cfg.mir),
        .skip(q.cfg.cskip),
        .nxt (col_nxt),
        .last(col_last)
    );

    axis_step #(.W(ROW_W)) u_row (
        .cur (q.row),
        .lo  (q.cfg.ys),
        .hi  (q.cfg.ye),
        .rev (q.cfg.flp),
        .skip(q.cfg.rskip),
        .nxt (row_nxt),
        .last(row_last)
    );

    assign col_first = q.cfg.mir ? q.cfg.xe : q.cfg.xs;

    always_comb begin
        d = q;
        unique case (q.ph)
            PH_IDLE: begin
                if (sof) begin
                    d.cfg.xs    = x_lo;
                    d.cfg.xe    = x_hi;
                    d.cfg.ys    = y_lo;
                    d.cfg.ye    = y_hi;
                    d.cfg.mir   = mirror;
                    d.cfg.flp   = flip;
                    d.cfg.cskip = col_skip;
                    d.cfg.rskip = row_skip;
                    d.cfg.gap   = gap_len;
                    d.row       = flip ? y_hi : y_lo;
                    d.col       = mirror ? x_hi : x_lo;
                    d.ph        = PH_LINE;
                end
            end
            PH_LINE: begin
                if (!col_last) begin
                    d.col = col_nxt;
                end else if (row_last) begin
                    d.ph = PH_IDLE;
                end else begin
                    d.row = row_nxt;
                    d.col = col_first;
                    if (q.cfg.gap != '0) begin
                        d.ph  = PH_GAP;
                        d.cnt = q.cfg.gap - GAP_W'(1);
                    end
                end
            end
            PH_GAP: begin
                if (q.cnt == '0) d.ph = PH_LINE;
                else             d.cnt = q.cnt - GAP_W'(1);
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign row_addr    = q.row;
    assign col_addr    = q.col;
    assign line_valid  = (q.ph == PH_LINE);
    assign frame_valid = (q.ph != PH_IDLE);

    // line strobe only inside the frame envelope
    p_lv_in_fv_r11: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> frame_valid);

    // presented addresses stay inside the captured window
    p_col_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> (col_addr >= q.cfg.xs && col_addr <= q.cfg.xe &&
                        row_addr >= q.cfg.ys && row_addr <= q.cfg.ye));

    // forward column scan increases within a row
    p_fwd_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && $past(line_valid) && row_addr == $past(row_addr) && !q.cfg.mir)
        |-> (col_addr > $past(col_addr)));

    // mirrored column scan decreases within a row
    p_rev_col_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && $past(line_valid) && row_addr == $past(row_addr) && q.cfg.mir)
        |-> (col_addr < $past(col_addr)));

    // consecutive pixels of a row are 1 apart, or 3 when skipping
    p_col_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && $past(line_valid) && row_addr == $past(row_addr))
        |-> ((col_addr - $past(col_addr) == COL_W'(1)) ||
             ($past(col_addr) - col_addr == COL_W'(1)) ||
             (q.cfg.cskip && ((col_addr - $past(col_addr) == COL_W'(3)) ||
                              ($past(col_addr) - col_addr == COL_W'(3))))));

    // captured settings hold for the whole frame
    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && $past(frame_valid)) |-> $stable(q.cfg));
endmodule

// File: tb/sim_readout_seq.sv
`timescale 1ns/1ps
module sim_readout_seq;
    import rdo_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sof = 1'b0;
    logic [COL_W-1:0] x_lo = '0, x_hi = '0;
    logic [ROW_W-1:0] y_lo = '0, y_hi = '0;
    logic             mirror = 1'b0, flip = 1'b0, col_skip = 1'b0, row_skip = 1'b0;
    logic [GAP_W-1:0] gap_len = '0;
    logic [ROW_W-1:0] row_addr;
    logic [COL_W-1:0] col_addr;
    logic             line_valid, frame_valid;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    readout_seq u0 (
        .clk(clk), .rst_n(rst_n), .sof(sof),
        .x_lo(x_lo), .x_hi(x_hi), .y_lo(y_lo), .y_hi(y_hi),
        .mirror(mirror), .flip(flip), .col_skip(col_skip), .row_skip(row_skip),
        .gap_len(gap_len),
        .row_addr(row_addr), .col_addr(col_addr),
        .line_valid(line_valid), .frame_valid(frame_valid)
    );

    task automatic chk(input bit ok, input string req, input string act, input string exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %s, expected %s", req, act, exp);
        end
    endtask

    function automatic void build(input int lo, input int hi, input bit rev,
                                  input bit skip, ref int lst[$]);
        lst.delete();
        for (int i = 0; i < 4096; i++) begin
            int off;
            off = skip ? ((i / 2) * 4 + (i % 2)) : i;
            if (off > hi - lo) break;
            lst.push_back(rev ? hi - off : lo + off);
        end
    endfunction

    task automatic run_frame(input int xs, input int xe, input int ys, input int ye,
                             input bit mir, input bit flp, input bit cs, input bit rs,
                             input int bl, input bit disturb);
        int cols[$];
        int rows[$];
        string tag;
        int cyc;
        build(xs, xe, mir, cs, cols);
        build(ys, ye, flp, rs, rows);
        tag = disturb ? "R10" : mir ? "R4" : flp ? "R5" : cs ? "R6" : rs ? "R7" : "R3";
        @(negedge clk);
        x_lo = COL_W'(xs); x_hi = COL_W'(xe); y_lo = ROW_W'(ys); y_hi = ROW_W'(ye);
        mirror = mir; flip = flp; col_skip = cs; row_skip = rs; gap_len = GAP_W'(bl);
        sof = 1'b1;
        @(negedge clk);
        sof = 1'b0;
        cyc = 0;
        for (int ri = 0; ri < rows.size(); ri++) begin
            for (int ci = 0; ci < cols.size(); ci++) begin
                // R11: pixel cycles carry both strobes
                chk(line_valid === 1'b1 && frame_valid === 1'b1 &&
                    row_addr == ROW_W'(rows[ri]) && col_addr == COL_W'(cols[ci]),
                    (cyc == 0) ? "R2" : tag,
                    $sformatf("lv=%0b fv=%0b row=%0d col=%0d", line_valid, frame_valid, row_addr, col_addr),
                    $sformatf("lv=1 fv=1 row=%0d col=%0d", rows[ri], cols[ci]));
                if (disturb && cyc == 0) begin
                    x_lo = COL_W'(0); x_hi = COL_W'(1599); y_lo = ROW_W'(0); y_hi = ROW_W'(1199);
                    mirror = ~mir; flip = ~flp; col_skip = ~cs; row_skip = ~rs;
                    gap_len = GAP_W'(bl + 3);
                    sof = 1'b1;
                end else if (disturb && cyc == 1) begin
                    sof = 1'b0;
                end
                cyc++;
                @(negedge clk);
            end
            if (ri != rows.size() - 1) begin
                for (int g = 0; g < bl; g++) begin
                    chk(line_valid === 1'b0 && frame_valid === 1'b1, "R8",
                        $sformatf("lv=%0b fv=%0b", line_valid, frame_valid), "lv=0 fv=1");
                    if (disturb && cyc == 1) sof = 1'b0;
                    cyc++;
                    @(negedge clk);
                end
            end
        end
        sof = 1'b0;
        chk(line_valid === 1'b0 && frame_valid === 1'b0, "R9",
            $sformatf("lv=%0b fv=%0b", line_valid, frame_valid), "lv=0 fv=0");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(line_valid === 1'b0 && frame_valid === 1'b0, "R1",
            $sformatf("lv=%0b fv=%0b", line_valid, frame_valid), "lv=0 fv=0");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(line_valid === 1'b0 && frame_valid === 1'b0, "R1",
            $sformatf("lv=%0b fv=%0b", line_valid, frame_valid), "lv=0 fv=0");

        for (int m = 0; m < 16; m++) begin
            for (int b = 0; b < 2; b++) begin
                int bl;
                bl = b * 2;
                run_frame(3, 12, 5, 13, m[0], m[1], m[2], m[3], bl, 1'b0);
                run_frame(7, 7, 9, 9, m[0], m[1], m[2], m[3], bl, 1'b0);
                run_frame(1590, 1599, 1193, 1199, m[0], m[1], m[2], m[3], bl, 1'b0);
                run_frame(2, 8, 4, 9, m[0], m[1], m[2], m[3], bl + 1, 1'b1);
            end
        end

        repeat (2) @(negedge clk);
        chk(line_valid === 1'b0 && frame_valid === 1'b0, "R10",
            $sformatf("lv=%0b fv=%0b", line_valid, frame_valid), "lv=0 fv=0");

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule